// File: doc/BRIEF.md
# Block-Aligned Instruction Fetch with Decoupling Queue

This block is the front of a superscalar core. Every cycle it presents the aligned address of the cache block that holds the current fetch PC. It receives that block back in the same cycle: SLOTS instructions of 4 bytes each, so 16 or 32 bytes. It receives a per-slot predicted-taken mask and one predicted target along with it. From the block it cuts the run that starts at the fetch PC and ends either at the last slot of the block or at the first predicted-taken slot, whichever comes first. It appends that run to a multi-entry instruction queue.

Decode reads up to W instructions per cycle from the head of the queue in program order. Fetch delivers anywhere from one instruction to a full block per cycle. The queue smooths these uneven amounts so that decode sees a steady supply. A redirect port, driven on a misprediction, discards the queue contents and restarts fetch at a corrected address.

Top module: `fetch_front`

## Requirements
- R1: While reset is held, and until the first clock edge after its release, `deq_valid` is all zero and `fetch_addr` is the block base of RESET_PC (0x100 by default).
- R2: `fetch_addr` is always the fetch PC with its low log2(4*SLOTS) bits cleared. Slot s of `blk_data` (bits 32s+31..32s) is the instruction at `fetch_addr + 4s`.
- R3: With no taken mark at or after the start slot (PC bits log2(4*SLOTS)-1..2), the run covers the start slot through slot SLOTS-1, and the next fetch PC is `fetch_addr + 4*SLOTS`.
- R4: A fetch PC in the last slot of a block delivers exactly one instruction in that cycle.
- R5: The run ends with, and includes, the lowest slot at or above the start slot whose `taken_mask` bit is 1. The next fetch PC is then `taken_target`. Taken marks below the start slot have no effect.
- R6: A run is written only when the free entries, counted before this cycle's pop, are at least its length. Otherwise the fetch PC holds, nothing is written, and no entry is lost or duplicated. Occupancy never exceeds QDEPTH.
- R7: Lanes 0..n-1 of the decode outputs are valid, where n = min(W, occupancy). They carry the oldest entries in program order, lane 0 being the oldest, with `deq_pc` lane k at bits AW*k+AW-1..AW*k and `deq_insn` lane k at bits 32k+31..32k. When `deq_ready` is 1, those n entries are removed at the clock edge.
- R8: When `redir_valid` is 1 at an edge, the queue is empty after it, the run fetched in that cycle is discarded, and the next fetch PC is `redir_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | AW | Aligned block address to read |
| blk_data | input | 32*SLOTS | Block contents, slot s at bits 32s+31..32s |
| taken_mask | input | SLOTS | Predicted-taken mark per slot |
| taken_target | input | AW | Predicted target of the first taken slot |
| redir_valid | input | 1 | Flush the queue and restart fetch |
| redir_pc | input | AW | Restart address |
| deq_ready | input | 1 | Decode takes the valid head lanes this cycle |
| deq_valid | output | W | Valid lane mask, contiguous from lane 0 |
| deq_insn | output | 32*W | Head instructions |
| deq_pc | output | AW*W | Addresses of the head instructions |

## Verification
A redirect shows up at the ports at the first sampling point after the edge that takes it: the decode lanes are empty and `fetch_addr` already shows the new block. The run fetched in the cycle after that becomes visible on the decode lanes one edge later, when `fetch_addr` moves on to the next PC. The bench drives inputs and samples outputs only on falling edges, so every check falls a whole number of edges after its stimulus. Popped entries are checked as they leave the queue against an expected address list for each scenario. That list catches loss, duplication and misordering across stalls, taken branches and flushes.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
   localparam int INSN_W     = 32;
   localparam int INSN_BYTES = 4;
endpackage

// File: rtl/fetch_extract.sv
module fetch_extract
   import fetch_pkg::*;
#(
   parameter int SLOTS = 4,
   parameter int AW    = 32
) (
   input  logic [AW-1:0]    pc,
   input  logic [SLOTS-1:0] taken_mask,
   input  logic [AW-1:0]    taken_target,
   output logic [AW-1:0]    base,
   output logic [$clog2(SLOTS)-1:0] start,
   output logic [$clog2(SLOTS):0]   cnt,
   output logic             hit,
   output logic [AW-1:0]    next_pc
);
   localparam int SW        = $clog2(SLOTS);
   localparam int BLK_BYTES = SLOTS * INSN_BYTES;
   localparam int OB        = $clog2(BLK_BYTES);

   logic [SW:0] last;

   always_comb begin
      base  = pc & ~AW'(BLK_BYTES - 1);
      start = pc[OB-1:2];
      hit   = 1'b0;
      last  = (SW+1)'(SLOTS - 1);
      for (int i = 0; i < SLOTS; i++) begin
         if (!hit && ((SW+1)'(i) >= {1'b0, start}) && taken_mask[i]) begin
            hit  = 1'b1;
            last = (SW+1)'(i);
         end
      end
      cnt     = last - {1'b0, start} + (SW+1)'(1);
      next_pc = hit ? taken_target : base + AW'(BLK_BYTES);
   end
endmodule

// File: rtl/fetch_queue.sv
module fetch_queue #(
   parameter int QDEPTH = 18,
   parameter int SLOTS  = 4,
   parameter int W      = 2,
   parameter int DW     = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push_en,
   input  logic [$clog2(SLOTS):0]     push_n,
   input  logic [SLOTS-1:0][DW-1:0]   push_data,
   input  logic                       pop_en,
   output logic [W-1:0][DW-1:0]       head_data,
   output logic [W-1:0]               head_valid,
   output logic [$clog2(QDEPTH+1)-1:0] room
);
   localparam int PW      = $clog2(QDEPTH);
   localparam int CW      = $clog2(QDEPTH + 1);
   localparam bit IS_POW2 = (1 << PW) == QDEPTH;
   localparam logic [PW:0] QD_P = (PW+1)'(QDEPTH);

   function automatic logic [PW-1:0] wrap(input logic [PW:0] s);
      if (IS_POW2) return s[PW-1:0];
      else return (s >= QD_P) ? PW'(s - QD_P) : s[PW-1:0];
   endfunction

   logic [DW-1:0]   mem [QDEPTH];
   logic [PW-1:0]   wr_q, rd_q;
   logic [CW-1:0]   count_q;
   logic [CW-1:0]   pop_n;
   logic [PW-1:0]   wr_idx [SLOTS];
   logic [PW-1:0]   rd_idx [W];

   for (genvar j = 0; j < SLOTS; j++) begin : g_wr
      assign wr_idx[j] = wrap({1'b0, wr_q} + (PW+1)'(j));
   end

   for (genvar k = 0; k < W; k++) begin : g_rd
      assign rd_idx[k]     = wrap({1'b0, rd_q} + (PW+1)'(k));
      assign head_data[k]  = mem[rd_idx[k]];
      assign head_valid[k] = count_q > CW'(k);
   end

   assign pop_n = !pop_en ? '0 : (count_q < CW'(W)) ? count_q : CW'(W);
   assign room  = CW'(QDEPTH) - count_q;

   always_ff @(posedge clk) begin
      for (int j = 0; j < SLOTS; j++) begin
         if (push_en && !flush && ((SLOTS+1)'(j) < (SLOTS+1)'(push_n)))
            mem[wr_idx[j]] <= push_data[j];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_q    <= '0;
         rd_q    <= '0;
         count_q <= '0;
      end else begin
         if (push_en) wr_q <= wrap({1'b0, wr_q} + (PW+1)'(push_n));
         rd_q    <= wrap({1'b0, rd_q} + (PW+1)'(pop_n));
         count_q <= count_q + (push_en ? CW'(push_n) : CW'(0)) - pop_n;
      end
   end

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(QDEPTH));

   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0));
endmodule

// File: rtl/fetch_front.sv
module fetch_front
   import fetch_pkg::*;
#(
   parameter int          SLOTS    = 4,
   parameter int          W        = 2,
   parameter int          QDEPTH   = 18,
   parameter int          AW       = 32,
   parameter logic [31:0] RESET_PC = 32'h100
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [AW-1:0]       fetch_addr,
   input  logic [INSN_W*SLOTS-1:0] blk_data,
   input  logic [SLOTS-1:0]    taken_mask,
   input  logic [AW-1:0]       taken_target,
   input  logic                redir_valid,
   input  logic [AW-1:0]       redir_pc,
   input  logic                deq_ready,
   output logic [W-1:0]        deq_valid,
   output logic [INSN_W*W-1:0] deq_insn,
   output logic [AW*W-1:0]     deq_pc
);
   localparam int SW = $clog2(SLOTS);
   localparam int CW = $clog2(QDEPTH + 1);
   localparam int DW = AW + INSN_W;

   if (!(SLOTS == 4 || SLOTS == 8)) begin : g_bad_slots
      $error("SLOTS must be 4 or 8");
   end
   if (W < 1 || W > SLOTS) begin : g_bad_width
      $error("W must lie in 1..SLOTS");
   end
   if (QDEPTH < SLOTS) begin : g_bad_depth
      $error("QDEPTH must hold a full block");
   end

   logic [AW-1:0]             pc_q;
   logic [AW-1:0]             base, next_pc;
   logic [SW-1:0]             start;
   logic [SW:0]               cnt;
   logic                      hit;
   logic [CW-1:0]             room;
   logic                      room_ok, push_en;
   logic [SLOTS-1:0][DW-1:0]  run_data;
   logic [W-1:0][DW-1:0]      head_data;

   fetch_extract #(.SLOTS(SLOTS), .AW(AW)) extract_i (
      .pc(pc_q), .taken_mask(taken_mask), .taken_target(taken_target),
      .base(base), .start(start), .cnt(cnt), .hit(hit), .next_pc(next_pc)
   );

   always_comb begin
      for (int j = 0; j < SLOTS; j++) begin
         int idx;
         idx = int'(start) + j;
         if (idx < SLOTS)
            run_data[j] = {base + AW'(idx * INSN_BYTES), blk_data[idx*INSN_W +: INSN_W]};
         else
            run_data[j] = '0;
      end
   end

   assign room_ok    = room >= CW'(cnt);
   assign push_en    = room_ok && !redir_valid;
   assign fetch_addr = base;

   fetch_queue #(.QDEPTH(QDEPTH), .SLOTS(SLOTS), .W(W), .DW(DW)) queue_i (
      .clk(clk), .rst_n(rst_n), .flush(redir_valid), .push_en(push_en),
      .push_n(cnt), .push_data(run_data), .pop_en(deq_ready),
      .head_data(head_data), .head_valid(deq_valid), .room(room)
   );

   for (genvar k = 0; k < W; k++) begin : g_lane
      assign deq_pc[k*AW +: AW]           = head_data[k][DW-1:INSN_W];
      assign deq_insn[k*INSN_W +: INSN_W] = head_data[k][INSN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           pc_q <= AW'(RESET_PC);
      else if (redir_valid) pc_q <= redir_pc;
      else if (push_en)     pc_q <= next_pc;
   end

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_valid && !room_ok) |=> $stable(fetch_addr));

   p_last_slot_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start == SW'(SLOTS - 1)) |-> (cnt == (SW+1)'(1)));

   p_taken_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && taken_mask[start]) |=> (pc_q == $past(taken_target)));

   p_seq_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && taken_mask == '0) |=>
         (fetch_addr == $past(fetch_addr) + AW'(SLOTS * INSN_BYTES)));

   p_valid_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((deq_valid + W'(1)) & deq_valid) == '0);
endmodule

// File: tb/fetch_front_tb_top.sv
`timescale 1ns/1ps
module fetch_front_tb_top;
   localparam int SL = 4;
   localparam int W  = 2;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] fetch_addr;
   logic [32*SL-1:0] blk_data;
   logic [SL-1:0] taken_mask;
   logic [AW-1:0] taken_target;
   logic redir_valid = 1'b0;
   logic [AW-1:0] redir_pc = '0;
   logic deq_ready = 1'b0;
   logic [W-1:0] deq_valid;
   logic [32*W-1:0] deq_insn;
   logic [AW*W-1:0] deq_pc;

   logic [AW-1:0] tk_blk  = 32'hFFFF_FFF0;
   logic [SL-1:0] tk_mask = '0;
   logic [AW-1:0] tk_tgt  = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [AW-1:0] exp_pc [32];

   always #5 clk = ~clk;

   fetch_front dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .blk_data(blk_data),
      .taken_mask(taken_mask), .taken_target(taken_target),
      .redir_valid(redir_valid), .redir_pc(redir_pc), .deq_ready(deq_ready),
      .deq_valid(deq_valid), .deq_insn(deq_insn), .deq_pc(deq_pc)
   );

   function automatic logic [31:0] word_at(input logic [AW-1:0] a);
      return a ^ 32'h5A5A_0000;
   endfunction

   always_comb begin
      for (int s = 0; s < SL; s++) blk_data[s*32 +: 32] = word_at(fetch_addr + AW'(4*s));
      taken_mask   = (fetch_addr == tk_blk) ? tk_mask : '0;
      taken_target = tk_tgt;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic flush_to(input logic [AW-1:0] a);
      redir_valid = 1'b1;
      redir_pc    = a;
      step();
      redir_valid = 1'b0;
   endtask

   function automatic logic [AW-1:0] lane_pc(input int k);
      return deq_pc[k*AW +: AW];
   endfunction

   task automatic expect_stream(input int n, input string req);
      int got = 0;
      int cyc = 0;
      deq_ready = 1'b1;
      while (got < n && cyc < 200) begin
         for (int k = 0; k < W; k++) begin
            if (deq_valid[k] && got < n) begin
               check(lane_pc(k) == exp_pc[got], req, lane_pc(k), exp_pc[got]);
               check(deq_insn[k*32 +: 32] == word_at(exp_pc[got]), req,
                     deq_insn[k*32 +: 32], word_at(exp_pc[got]));
               got++;
            end
         end
         check(((deq_valid + W'(1)) & deq_valid) == '0, "R7 contiguous lanes", deq_valid, 0);
         step();
         cyc++;
      end
      check(got == n, req, got, n);
      deq_ready = 1'b0;
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      check(deq_valid == '0, "R1 valid in reset", deq_valid, 0);
      check(fetch_addr == 32'h100, "R1 fetch_addr in reset", fetch_addr, 32'h100);
      rst_n = 1'b1;
      check(deq_valid == '0, "R1 valid after release", deq_valid, 0);
      step();
   endtask

   task automatic test_seq_fill();
      deq_ready = 1'b0;
      flush_to(32'h208);
      check(deq_valid == '0, "R8 empty after flush", deq_valid, 0);
      check(fetch_addr == 32'h200, "R2 aligned base", fetch_addr, 32'h200);
      step();
      check(deq_valid == 2'b11, "R3 run to block end", deq_valid, 2'b11);
      check(lane_pc(0) == 32'h208, "R3 first lane", lane_pc(0), 32'h208);
      check(lane_pc(1) == 32'h20C, "R3 second lane", lane_pc(1), 32'h20C);
      check(fetch_addr == 32'h210, "R3 next block", fetch_addr, 32'h210);
      repeat (4) step();
      check(fetch_addr == 32'h250, "R3 sequential blocks", fetch_addr, 32'h250);
      repeat (3) step();
      check(fetch_addr == 32'h250, "R6 stall holds pc", fetch_addr, 32'h250);
      check(lane_pc(0) == 32'h208, "R6 head unchanged", lane_pc(0), 32'h208);
      for (int i = 0; i < 30; i++) exp_pc[i] = 32'h208 + AW'(4*i);
      expect_stream(30, "R6 R7 stream order");
   endtask

   task automatic test_last_slot();
      deq_ready = 1'b0;
      flush_to(32'h30C);
      step();
      check(deq_valid == 2'b01, "R4 single insn", deq_valid, 2'b01);
      check(lane_pc(0) == 32'h30C, "R4 last slot pc", lane_pc(0), 32'h30C);
      check(fetch_addr == 32'h310, "R4 next block", fetch_addr, 32'h310);
      step();
      check(deq_valid == 2'b11, "R7 both lanes", deq_valid, 2'b11);
      check(lane_pc(1) == 32'h310, "R7 order across runs", lane_pc(1), 32'h310);
   endtask

   task automatic test_taken();
      tk_blk = 32'h400; tk_mask = 4'b0110; tk_tgt = 32'h528;
      deq_ready = 1'b0;
      flush_to(32'h404);
      step();
      check(deq_valid == 2'b01, "R5 stop at taken", deq_valid, 2'b01);
      check(fetch_addr == 32'h520, "R5 target block", fetch_addr, 32'h520);
      exp_pc[0] = 32'h404; exp_pc[1] = 32'h528; exp_pc[2] = 32'h52C;
      exp_pc[3] = 32'h530; exp_pc[4] = 32'h534;
      expect_stream(5, "R5 taken stream");

      tk_mask = 4'b0001;
      flush_to(32'h404);
      step();
      check(fetch_addr == 32'h410, "R5 mark below start ignored", fetch_addr, 32'h410);
      for (int i = 0; i < 6; i++) exp_pc[i] = 32'h404 + AW'(4*i);
      expect_stream(6, "R5 ignored mark stream");

      tk_mask = 4'b0100;
      flush_to(32'h400);
      exp_pc[0] = 32'h400; exp_pc[1] = 32'h404; exp_pc[2] = 32'h408;
      exp_pc[3] = 32'h528; exp_pc[4] = 32'h52C;
      expect_stream(5, "R5 taken inside run");
      tk_blk = 32'hFFFF_FFF0; tk_mask = '0;
   endtask

   task automatic test_flush_priority();
      deq_ready = 1'b0;
      flush_to(32'h600);
      repeat (2) step();
      flush_to(32'h700);
      check(deq_valid == '0, "R8 flush beats push", deq_valid, 0);
      check(fetch_addr == 32'h700, "R8 redirect pc", fetch_addr, 32'h700);
      step();
      check(lane_pc(0) == 32'h700, "R8 restart head", lane_pc(0), 32'h700);
      deq_ready = 1'b1;
      flush_to(32'h744);
      check(deq_valid == '0, "R8 flush with pop", deq_valid, 0);
      for (int i = 0; i < 4; i++) exp_pc[i] = 32'h744 + AW'(4*i);
      expect_stream(4, "R8 stream after flush");
   endtask

   initial begin
      test_reset();
      test_seq_fill();
      test_last_slot();
      test_taken();
      test_flush_priority();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule